// File: doc/BRIEF.md
# Parallel Port Handshake Engine

This block moves bytes between a core and an 8-bit parallel port using two control wires: an active-low "data available" strobe and a "ready" line. A direction input chooses which way the port runs. When it runs as an output, the strobe is driven by this block and the ready line is read. When it runs as an input, the strobe is read and the ready line is driven. A mode input chooses between two protocols. Strobed mode uses a pulse of fixed width and no acknowledge. Interlocked mode uses a four-phase exchange in which every edge of the strobe waits for the partner's ready line.

On the core side, bytes to send are offered with a valid/ready pair, and received bytes come back the same way from a one-entry buffer. All pin inputs pass through a two-stage synchronizer before any edge on them is detected. Two fields, programmable in clock cycles, set the data setup ahead of the output strobe and the width of that strobe. Software is expected to load 2 into each.

Top module: `hs_port_engine`

## Requirements
- R1: After reset, the output strobe reads high, the data output enable is low, the ready output reads high and no received byte is offered to the core.
- R2: In output direction, a new byte appears on the data pins exactly `cfg_setup` cycles before the strobe falls. The data pins do not change while the strobe is low.
- R3: In strobed output mode, the strobe stays low for exactly `cfg_width` cycles whatever the ready input does. The engine accepts a byte while the ready input is held low.
- R4: In interlocked output mode, the strobe stays low for at least `cfg_width` cycles. It rises only after the synchronized ready input has gone low.
- R5: In interlocked output mode, a new byte is not accepted while the ready input is low. After the strobe rises, the next strobe falls no sooner than `cfg_setup`+3 cycles after the ready input returns high.
- R6: In input direction, the byte present on the data pins when the strobe falls is delivered to the core in arrival order.
- R7: While a received byte waits unconsumed, the ready output is low. A strobe fall in that time is ignored, and the buffered byte stays unchanged.
- R8: In interlocked input mode, the ready output returns high only once the byte has been consumed and the strobe has risen again.
- R9: When the core consumes the buffered byte in the same cycle that a new strobe fall is detected, the new byte is captured.
- R10: The disabled direction is quiet. In input direction, the strobe output stays high, the data output enable is low and no byte is accepted for sending. In output direction, the ready output stays high and strobe edges on the input pin capture nothing.
- R11: A `cfg_setup` or `cfg_width` value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_dir | input | 1 | 1 = output direction, 0 = input direction |
| ilk_mode | input | 1 | 1 = interlocked four-phase, 0 = strobed |
| cfg_setup | input | CNT_W | Data setup before strobe, and tail after it, in cycles |
| cfg_width | input | CNT_W | Output strobe low width in cycles |
| tx_valid | input | 1 | Core offers a byte to send |
| tx_data | input | DATA_W | Byte to send |
| tx_ready | output | 1 | Engine accepts the offered byte |
| rx_valid | output | 1 | A received byte is buffered |
| rx_data | output | DATA_W | Buffered received byte |
| rx_ready | input | 1 | Core consumes the buffered byte |
| pin_data_i | input | DATA_W | Data pins, incoming |
| pin_data_o | output | DATA_W | Data pins, outgoing |
| pin_data_oe | output | 1 | Data pin output enable |
| pin_dav_n_i | input | 1 | Incoming active-low strobe |
| pin_dav_n_o | output | 1 | Outgoing active-low strobe |
| pin_rdy_i | input | 1 | Incoming ready |
| pin_rdy_o | output | 1 | Outgoing ready |

## Verification
In input direction, two events can land on the same clock edge: the core draining the one-entry buffer and the detection of a fresh strobe fall. The bench drops the strobe while the buffer is full. It then raises the core's consume signal for exactly one cycle, timed to the edge on which the fall clears the two synchronizer stages. The first byte must be delivered, and right after that edge the buffer must hold the second byte. The overflow case is checked separately. There, a fall arrives with no consume, and the first byte must come out alone with nothing behind it.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_SETUP,
        TX_STROBE,
        TX_WAIT_ACK,
        TX_WAIT_REL,
        TX_TAIL
    } tx_state_e;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = d;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '{s1: RST_VAL, s2: RST_VAL};
        else        sync_q <= sync_d;
    end

    assign q = sync_q.s2;
endmodule

// File: rtl/hs_tx.sv
module hs_tx
    import hs_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          ilk,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_width,
    input  logic          tx_valid,
    input  logic [DW-1:0] tx_data,
    output logic          tx_ready,
    input  logic          rdy_s,
    output logic [DW-1:0] pin_data,
    output logic          pin_dav_n
);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        tx_state_e     st;
        logic [CW-1:0] cnt;
        logic          dav_n;
        logic [DW-1:0] data;
    } tx_t;

    tx_t tx_d, tx_q;
    logic [CW-1:0] s_eff, w_eff;

    assign s_eff = (cfg_setup == '0) ? ONE : cfg_setup;
    assign w_eff = (cfg_width == '0) ? ONE : cfg_width;
    assign tx_ready = en && (tx_q.st == TX_IDLE) && (!ilk || rdy_s);

    always_comb begin
        tx_d = tx_q;
        unique case (tx_q.st)
            TX_IDLE: begin
                if (tx_valid && tx_ready) begin
                    tx_d.data = tx_data;
                    tx_d.st   = TX_SETUP;
                    tx_d.cnt  = s_eff;
                end
            end
            TX_SETUP: begin
                if (tx_q.cnt <= ONE) begin
                    tx_d.st    = TX_STROBE;
                    tx_d.cnt   = w_eff;
                    tx_d.dav_n = 1'b0;
                end else begin
                    tx_d.cnt = tx_q.cnt - ONE;
                end
            end
            TX_STROBE: begin
                if (tx_q.cnt <= ONE) begin
                    if (ilk) begin
                        tx_d.st = TX_WAIT_ACK;
                    end else begin
                        tx_d.dav_n = 1'b1;
                        tx_d.st    = TX_TAIL;
                        tx_d.cnt   = s_eff;
                    end
                end else begin
                    tx_d.cnt = tx_q.cnt - ONE;
                end
            end
            TX_WAIT_ACK: begin
                if (!rdy_s) begin
                    tx_d.dav_n = 1'b1;
                    tx_d.st    = TX_WAIT_REL;
                end
            end
            TX_WAIT_REL: begin
                if (rdy_s) begin
                    tx_d.st  = TX_TAIL;
                    tx_d.cnt = s_eff;
                end
            end
            TX_TAIL: begin
                if (tx_q.cnt <= ONE) tx_d.st = TX_IDLE;
                else                 tx_d.cnt = tx_q.cnt - ONE;
            end
            default: tx_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '{st: TX_IDLE, cnt: '0, dav_n: 1'b1, data: '0};
        else        tx_q <= tx_d;
    end

    assign pin_data  = tx_q.data;
    assign pin_dav_n = tx_q.dav_n;

    // Length of the current low phase of the strobe, for the width check
    logic [CW:0] low_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 low_run_q <= '0;
        else if (tx_q.dav_n)        low_run_q <= '0;
        else if (low_run_q != '1)   low_run_q <= low_run_q + 1'b1;
    end

    AST_DATA_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_q.dav_n && !$past(tx_q.dav_n)) |-> $stable(tx_q.data)); // R2
    AST_STROBED_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!ilk && $rose(tx_q.dav_n)) |-> (low_run_q == {1'b0, w_eff})); // R3
    AST_ILK_REL_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (ilk && $rose(tx_q.dav_n)) |-> !$past(rdy_s)); // R4
endmodule

// File: rtl/hs_rx.sv
module hs_rx #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          ilk,
    input  logic          dav_s,
    input  logic [DW-1:0] data_s,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data,
    input  logic          rx_ready,
    output logic          pin_rdy
);
    typedef struct packed {
        logic          full;
        logic [DW-1:0] buffer;
        logic          dav_prev;
        logic          rdy;
    } rx_t;

    rx_t rx_d, rx_q;
    logic dav_v, fall, pop;

    assign dav_v = en ? dav_s : 1'b1;
    assign fall  = rx_q.dav_prev && !dav_v;
    assign pop   = rx_q.full && rx_ready;

    always_comb begin
        rx_d          = rx_q;
        rx_d.dav_prev = dav_v;
        if (pop) rx_d.full = 1'b0;
        if (fall && (!rx_q.full || pop)) begin
            rx_d.full   = 1'b1;
            rx_d.buffer = data_s;
        end
        rx_d.rdy = !rx_d.full && (!ilk || dav_v);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '{full: 1'b0, buffer: '0, dav_prev: 1'b1, rdy: 1'b1};
        else        rx_q <= rx_d;
    end

    assign rx_valid = rx_q.full;
    assign rx_data  = rx_q.buffer;
    assign pin_rdy  = rx_q.rdy;

    AST_RX_BUF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.full && !rx_ready) |=> (rx_q.full && $stable(rx_q.buffer))); // R7
    AST_RX_RDY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ilk && $rose(rx_q.rdy)) |-> ($past(dav_v) && !rx_q.full)); // R8
endmodule

// File: rtl/hs_port_engine.sv
module hs_port_engine #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_dir,
    input  logic              ilk_mode,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_width,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    input  logic              rx_ready,
    input  logic [DATA_W-1:0] pin_data_i,
    output logic [DATA_W-1:0] pin_data_o,
    output logic              pin_data_oe,
    input  logic              pin_dav_n_i,
    output logic              pin_dav_n_o,
    input  logic              pin_rdy_i,
    output logic              pin_rdy_o
);
    localparam int unsigned SW = DATA_W + 2;
    localparam logic [SW-1:0] SYNC_RST = {2'b11, {DATA_W{1'b0}}};

    logic [SW-1:0]     sync_out;
    logic              rdy_s, dav_s;
    logic [DATA_W-1:0] data_s;
    logic              tx_dav_n, rx_rdy;

    hs_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pin_rdy_i, pin_dav_n_i, pin_data_i}),
        .q     (sync_out)
    );

    assign {rdy_s, dav_s, data_s} = sync_out;

    hs_tx #(.DW(DATA_W), .CW(CNT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (port_dir),
        .ilk       (ilk_mode),
        .cfg_setup (cfg_setup),
        .cfg_width (cfg_width),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready),
        .rdy_s     (rdy_s),
        .pin_data  (pin_data_o),
        .pin_dav_n (tx_dav_n)
    );

    hs_rx #(.DW(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (!port_dir),
        .ilk      (ilk_mode),
        .dav_s    (dav_s),
        .data_s   (data_s),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_ready (rx_ready),
        .pin_rdy  (rx_rdy)
    );

    assign pin_data_oe = port_dir;
    assign pin_dav_n_o = port_dir ? tx_dav_n : 1'b1;
    assign pin_rdy_o   = port_dir ? 1'b1 : rx_rdy;
endmodule

// File: tb/sim_hs_port_engine.sv
module sim_hs_port_engine;
    localparam int DW = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          port_dir = 1'b0;
    logic          ilk_mode = 1'b1;
    logic [CW-1:0] cfg_setup = 4'd2;
    logic [CW-1:0] cfg_width = 4'd2;
    logic          tx_valid = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic          tx_ready;
    logic          rx_valid;
    logic [DW-1:0] rx_data;
    logic          rx_ready;
    logic [DW-1:0] pin_data_i = '0;
    logic [DW-1:0] pin_data_o;
    logic          pin_data_oe;
    logic          pin_dav_n_i = 1'b1;
    logic          pin_dav_n_o;
    logic          pin_rdy_i;
    logic          pin_rdy_o;

    logic auto_rx = 1'b1, auto_rdy = 1'b0, man_rdy = 1'b0;
    logic resp_en = 1'b1, resp_rdy = 1'b1, man_rdy_i = 1'b1;
    assign rx_ready  = auto_rx ? auto_rdy : man_rdy;
    assign pin_rdy_i = resp_en ? resp_rdy : man_rdy_i;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [DW-1:0] tx_exp[$];
    logic [DW-1:0] rx_exp[$];
    logic [DW-1:0] nb = 8'h11;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hs_port_engine #(.DATA_W(DW), .CNT_W(CW)) u0 (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff(input logic [CW-1:0] v);
        return (v == '0) ? 1 : int'(v);
    endfunction

    function automatic logic [DW-1:0] next_byte();
        nb = nb + 8'h13;
        return nb;
    endfunction

    // ---------------- core-side receive monitor (scoreboard) ----------------
    always begin
        @(negedge clk);
        if (auto_rx) auto_rdy = (cyc % 3) != 0;
        #1;
        if (rst_n && rx_valid && rx_ready) begin
            if (rx_exp.size() == 0) check(1'b0, "R6 unexpected byte", rx_data, -1);
            else begin
                logic [DW-1:0] e;
                e = rx_exp.pop_front();
                check(rx_data == e, "R6 received byte", rx_data, e);
            end
        end
    end

    // ---------------- pin-side transmit monitor ----------------
    logic          m_prev_dav = 1'b1;
    logic [DW-1:0] m_prev_data = '0, m_held = '0;
    int m_age = 0, m_low = 0, m_rdy_hi = 0, m_rdy_lo = 0;
    bit m_stable = 1'b1;
    always begin
        @(negedge clk);
        #1;
        if (pin_rdy_i) begin m_rdy_hi++; m_rdy_lo = 0; end
        else           begin m_rdy_lo++; m_rdy_hi = 0; end
        if (pin_data_o != m_prev_data) m_age = 0; else m_age++;
        if (rst_n && port_dir) begin
            if (m_prev_dav && !pin_dav_n_o) begin
                if (tx_exp.size() == 0) check(1'b0, "R2 unexpected strobe", pin_data_o, -1);
                else begin
                    logic [DW-1:0] e;
                    e = tx_exp.pop_front();
                    check(pin_data_o == e, "R2 sent byte", pin_data_o, e);
                end
                check(m_age == eff(cfg_setup), "R2 setup cycles", m_age, eff(cfg_setup));
                check(pin_data_oe == 1'b1, "R10 output enable", pin_data_oe, 1);
                if (ilk_mode)
                    check(m_rdy_hi >= eff(cfg_setup) + 3, "R5 gap after ready", m_rdy_hi, eff(cfg_setup) + 3);
                m_held = pin_data_o; m_low = 1; m_stable = 1'b1;
            end else if (!pin_dav_n_o) begin
                m_low++;
                if (pin_data_o != m_held) m_stable = 1'b0;
            end else if (!m_prev_dav && pin_dav_n_o) begin
                check(m_stable, "R2 data stable while low", m_stable, 1);
                if (!ilk_mode)
                    check(m_low == eff(cfg_width), "R3 strobe width", m_low, eff(cfg_width));
                else begin
                    check(m_low >= eff(cfg_width), "R4 min strobe width", m_low, eff(cfg_width));
                    check(m_rdy_lo >= 2, "R4 release after ready low", m_rdy_lo, 2);
                end
            end
        end
        m_prev_dav  = pin_dav_n_o;
        m_prev_data = pin_data_o;
    end

    // ---------------- interlocked output partner ----------------
    always begin
        @(negedge clk);
        if (resp_en && ilk_mode && port_dir && !pin_dav_n_o && resp_rdy) begin
            repeat (2) @(negedge clk);
            resp_rdy = 1'b0;
            while (!pin_dav_n_o) @(negedge clk);
            repeat (3) @(negedge clk);
            resp_rdy = 1'b1;
        end
    end

    // ---------------- driver tasks ----------------
    task automatic tx_push(input logic [DW-1:0] b);
        @(negedge clk);
        tx_valid = 1'b1; tx_data = b;
        #1;
        while (!tx_ready) begin @(negedge clk); #1; end
        tx_exp.push_back(b);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic rx_send(input logic [DW-1:0] b, input bit push, input bit wait_rdy);
        @(negedge clk);
        if (wait_rdy) while (!pin_rdy_o) @(negedge clk);
        pin_data_i = b;
        repeat (2) @(negedge clk);
        pin_dav_n_i = 1'b0;
        if (push) rx_exp.push_back(b);
        if (ilk_mode) begin
            while (pin_rdy_o) @(negedge clk);
            pin_dav_n_i = 1'b1;
            while (!pin_rdy_o) @(negedge clk);
        end else begin
            repeat (2) @(negedge clk);
            pin_dav_n_i = 1'b1;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic wait_drain();
        while (tx_exp.size() != 0 || rx_exp.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    task automatic pop_once();
        @(negedge clk); man_rdy = 1'b1;
        @(negedge clk); man_rdy = 1'b0;
    endtask

    bit finished = 1'b0;
    initial begin
        #(8 * 150000);
        if (!finished) begin
            check(1'b0, "watchdog expired", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] b1, b2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(pin_rdy_o == 1'b1, "R1 ready after reset", pin_rdy_o, 1);
        check(rx_valid == 1'b0, "R1 no byte after reset", rx_valid, 0);
        check(pin_dav_n_o == 1'b1, "R1 strobe high after reset", pin_dav_n_o, 1);
        check(pin_data_oe == 1'b0, "R1 output enable low", pin_data_oe, 0);

        // Interlocked input, automatic consumer (R6)
        for (int i = 0; i < 4; i++) rx_send(next_byte(), 1'b1, 1'b1);
        wait_drain();

        // R8: consume while strobe still low
        auto_rx = 1'b0;
        b1 = next_byte();
        @(negedge clk); pin_data_i = b1;
        repeat (2) @(negedge clk);
        pin_dav_n_i = 1'b0; rx_exp.push_back(b1);
        while (!rx_valid) @(negedge clk);
        check(pin_rdy_o == 1'b0, "R8 ready low on capture", pin_rdy_o, 0);
        pop_once();
        repeat (4) @(negedge clk);
        check(pin_rdy_o == 1'b0, "R8 ready held while strobe low", pin_rdy_o, 0);
        pin_dav_n_i = 1'b1;
        repeat (4) @(negedge clk);
        check(pin_rdy_o == 1'b1, "R8 ready after strobe release", pin_rdy_o, 1);

        // Strobed input
        ilk_mode = 1'b0; auto_rx = 1'b1;
        for (int i = 0; i < 4; i++) rx_send(next_byte(), 1'b1, 1'b1);
        wait_drain();

        // R7 overflow ignored
        auto_rx = 1'b0;
        b1 = next_byte(); b2 = next_byte();
        rx_send(b1, 1'b1, 1'b1);
        repeat (2) @(negedge clk);
        check(rx_valid == 1'b1, "R7 byte buffered", rx_valid, 1);
        check(pin_rdy_o == 1'b0, "R7 ready low while full", pin_rdy_o, 0);
        rx_send(b2, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        check(rx_data == b1, "R7 buffer unchanged", rx_data, b1);
        pop_once();
        @(negedge clk); #1;
        check(rx_valid == 1'b0, "R7 second byte dropped", rx_valid, 0);
        check(rx_exp.size() == 0, "R7 first byte delivered", rx_exp.size(), 0);

        // R9 consume and capture on the same edge
        b1 = next_byte(); b2 = next_byte();
        rx_send(b1, 1'b1, 1'b1);
        repeat (2) @(negedge clk);
        pin_data_i = b2;
        repeat (2) @(negedge clk);
        pin_dav_n_i = 1'b0; rx_exp.push_back(b2);
        @(negedge clk);
        @(negedge clk); man_rdy = 1'b1;
        @(negedge clk); man_rdy = 1'b0;
        #1;
        check(rx_valid == 1'b1, "R9 new byte captured", rx_valid, 1);
        check(rx_data == b2, "R9 new byte value", rx_data, b2);
        check(rx_exp.size() == 1, "R9 old byte delivered", rx_exp.size(), 1);
        pin_dav_n_i = 1'b1;
        pop_once();
        repeat (3) @(negedge clk);

        // R10 input direction leaves transmit side quiet
        tx_valid = 1'b1; tx_data = 8'h5A;
        repeat (4) @(negedge clk); #1;
        check(tx_ready == 1'b0, "R10 no send accept in input dir", tx_ready, 0);
        check(pin_dav_n_o == 1'b1, "R10 strobe high in input dir", pin_dav_n_o, 1);
        check(pin_data_oe == 1'b0, "R10 oe low in input dir", pin_data_oe, 0);
        tx_valid = 1'b0;

        // Strobed output, ready held low (R3)
        port_dir = 1'b1; resp_en = 1'b0; man_rdy_i = 1'b0;
        repeat (4) @(negedge clk); #1;
        check(tx_ready == 1'b1, "R3 accept with ready low", tx_ready, 1);
        check(pin_rdy_o == 1'b1, "R10 ready high in output dir", pin_rdy_o, 1);
        pin_data_i = 8'hC3; pin_dav_n_i = 1'b0;
        repeat (4) @(negedge clk);
        pin_dav_n_i = 1'b1;
        repeat (4) @(negedge clk);
        check(rx_valid == 1'b0, "R10 input strobe ignored in output dir", rx_valid, 0);
        for (int i = 0; i < 3; i++) tx_push(next_byte());
        wait_drain();
        cfg_setup = 4'd3; cfg_width = 4'd1;
        for (int i = 0; i < 2; i++) tx_push(next_byte());
        wait_drain();
        // R11 zero settings act as one
        cfg_setup = 4'd0; cfg_width = 4'd0;
        for (int i = 0; i < 2; i++) tx_push(next_byte());
        wait_drain();

        // Interlocked output
        cfg_setup = 4'd2; cfg_width = 4'd2; ilk_mode = 1'b1;
        repeat (4) @(negedge clk); #1;
        check(tx_ready == 1'b0, "R5 no accept while ready low", tx_ready, 0);
        resp_rdy = 1'b1; resp_en = 1'b1;
        for (int i = 0; i < 3; i++) tx_push(next_byte());
        wait_drain();
        check(tx_exp.size() == 0 && rx_exp.size() == 0, "R6 queues drained",
              tx_exp.size() + rx_exp.size(), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule